// File: doc/BRIEF.md
# Write-Once Software Watchdog Timer

This block watches for periodic servicing by software and takes action when the servicing stops. A down-counter is loaded with a programmable period. Software restarts it by writing two fixed key values to a service port, one after the other. If the counter runs out first, the block either pulses a non-maskable interrupt request or drives a system reset request. A single protection word chooses which of the two. The same word holds the enable bit, the prescaler bit and the period.

The protection word leaves reset in a safe state: the watchdog is enabled, the period is at its maximum, the prescaler is on and the response is a reset. Software may write the word exactly once. Every later write is dropped until the next system reset, and a lock flag shows whether the write has been used. A reset that the watchdog causes itself is held for a fixed number of cycles. The block then starts again in its post-reset state, with the write opportunity restored.

Top module: `wdog_guard`

## Requirements
- R1: After reset, `cfg_rd` reads enable=1 (bit 0), NMI select=0 (bit 1), prescaler=1 (bit 2) and period all ones (bits CNT_W+2:3). `cfg_locked`, `wd_rst` and `wd_nmi` are all 0.
- R2: With no servicing after reset, `wd_rst` rises after exactly (2^CNT_W-1)·2^PRE_LOG clock edges, counted from the first edge after reset release.
- R3: The first write on `cfg_we` loads `cfg_wdata` into the protection word and sets `cfg_locked` on the next edge.
- R4: While `cfg_locked` is 1, writes on `cfg_we` leave `cfg_rd` and the timeout timing unchanged.
- R5: A `svc_we` write of KEY_A (0x556C) followed by a `svc_we` write of KEY_B (0xAA39) reloads the counter to the period and restarts the prescaler. No timeout occurs while this pair arrives more often than once per timeout period.
- R6: Any other service value, or KEY_B without a directly preceding KEY_A, does not reload the counter. Such a value clears a partly entered sequence.
- R7: When NMI select is 1, a timeout gives a `wd_nmi` pulse one cycle wide. The counter then reloads and keeps running, so pulses repeat every period.
- R8: When NMI select is 0, a timeout holds `wd_rst` high for exactly RST_HOLD cycles. After that, the state is the R1 state: unlocked, default protection word and full period.
- R9: With enable=0 there is never a `wd_nmi` or `wd_rst`.
- R10: With the prescaler bit at 0 the counter steps on every clock. With the prescaler bit at 1 it steps once every 2^PRE_LOG clocks, so a period P lasts P or P·2^PRE_LOG cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| cfg_we | input | 1 | Protection word write strobe |
| cfg_wdata | input | CNT_W+3 | Protection word write data |
| svc_we | input | 1 | Service key write strobe |
| svc_data | input | KEY_W | Service key value |
| wd_rst | output | 1 | Reset request, held for RST_HOLD cycles |
| wd_nmi | output | 1 | Non-maskable interrupt request, one-cycle pulse |
| cfg_rd | output | CNT_W+3 | Current protection word |
| cfg_locked | output | 1 | Protection word has been written since reset |

## Verification
The main function is exercised under several service patterns, each of which tells a different fault apart:
- **No service at all** exposes the default period and the default response.
- **Regular correct key pairs** show that the reload works.
- **Stray keys** show that an out-of-order or wrong key is not taken as a service. These are a lone second key, and a first key followed by a wrong value and then the second key.

The protection word is then written with the NMI response at period 20, unprescaled, and later at period 5, prescaled. The spacing between pulses tells the prescaler settings apart. A second write in the locked state shows whether the lock holds. A disabled setting, run well past any period, shows that the enable bit gates both outputs.

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int CNT_W    = 16,
  parameter int PRE_LOG  = 11,
  parameter int RST_HOLD = 16,
  parameter int KEY_W    = 16,
  parameter logic [KEY_W-1:0] KEY_A = 16'h556C,
  parameter logic [KEY_W-1:0] KEY_B = 16'hAA39
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CNT_W+2:0]   cfg_wdata,
  input  logic               svc_we,
  input  logic [KEY_W-1:0]   svc_data,
  output logic               wd_rst,
  output logic               wd_nmi,
  output logic [CNT_W+2:0]   cfg_rd,
  output logic               cfg_locked
);
  localparam int CFG_W = CNT_W + 3;
  localparam int HW    = $clog2(RST_HOLD + 1);
  localparam logic [CFG_W-1:0] CFG_INIT = {{CNT_W{1'b1}}, 3'b101};

  logic [CFG_W-1:0]   cfg;
  logic               locked, stage, nmi_q;
  logic [CNT_W-1:0]   cnt;
  logic [PRE_LOG-1:0] pre;
  logic [HW-1:0]      hold;

  wire en      = cfg[0];
  wire use_nmi = cfg[1];
  wire pre_on  = cfg[2];
  wire holding = (hold != '0);
  wire tick    = !pre_on || (&pre);
  wire fire    = !holding && en && tick && (cnt <= CNT_W'(1));
  wire take    = cfg_we && !locked;
  wire svc_ok  = svc_we && stage && (svc_data == KEY_B);
  wire reload  = fire || take || svc_ok || !en;
  wire [CNT_W-1:0] next_period = take ? cfg_wdata[CFG_W-1:3] : cfg[CFG_W-1:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_INIT; locked <= 1'b0; stage <= 1'b0; nmi_q <= 1'b0;
      cnt <= '1; pre <= '0; hold <= '0;
    end else if (holding || (fire && !use_nmi)) begin
      cfg <= CFG_INIT; locked <= 1'b0; stage <= 1'b0; nmi_q <= 1'b0;
      cnt <= '1; pre <= '0;
      hold <= holding ? hold - 1'b1 : HW'(RST_HOLD);
    end else begin
      nmi_q <= fire;
      if (svc_we) stage <= (svc_data == KEY_A);
      if (take) begin
        cfg    <= cfg_wdata;
        locked <= 1'b1;
      end
      if (reload) begin
        cnt <= next_period;
        pre <= '0;
      end else begin
        if (tick) cnt <= cnt - 1'b1;
        pre <= pre + 1'b1;
      end
    end
  end

  assign wd_rst     = holding;
  assign wd_nmi     = nmi_q;
  assign cfg_rd     = cfg;
  assign cfg_locked = locked;
endmodule

module wdog_guard_chk #(
  parameter int CNT_W    = 16,
  parameter int RST_HOLD = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             wd_rst,
  input logic             wd_nmi,
  input logic [CNT_W+2:0] cfg_rd,
  input logic             cfg_locked
);
  logic [31:0] hcnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hcnt <= '0;
    else hcnt <= wd_rst ? hcnt + 32'd1 : 32'd0;

  assert_first_write_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_locked && !wd_rst) |=> (cfg_locked || wd_rst));

  assert_locked_word_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> (wd_rst || $stable(cfg_rd)));

  assert_nmi_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_nmi |=> !wd_nmi);

  assert_hold_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_rst) |-> (hcnt == RST_HOLD));

  assert_unlock_only_by_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_locked) |-> wd_rst);

  assert_no_dual_response_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wd_rst && wd_nmi));

  assert_disabled_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rd[0] && !wd_rst) |=> (!wd_nmi && !wd_rst));
endmodule

bind wdog_guard wdog_guard_chk #(.CNT_W(CNT_W), .RST_HOLD(RST_HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .wd_rst(wd_rst), .wd_nmi(wd_nmi),
  .cfg_rd(cfg_rd), .cfg_locked(cfg_locked));

// File: tb/test_wdog_guard.sv
`timescale 1ns/1ps
module test_wdog_guard;
  localparam int CNT_W = 8, PRE_LOG = 4, HOLD = 16, CFG_W = CNT_W + 3;
  localparam logic [15:0] KA = 16'h556C, KB = 16'hAA39;
  localparam int DEF_CFG = 32'h7FD;

  logic clk = 0, rst_n = 0, cfg_we = 0, svc_we = 0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic [15:0] svc_data = '0;
  logic wd_rst, wd_nmi, cfg_locked;
  logic [CFG_W-1:0] cfg_rd;

  wdog_guard #(.CNT_W(CNT_W), .PRE_LOG(PRE_LOG), .RST_HOLD(HOLD)) i_wdog_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .svc_we(svc_we), .svc_data(svc_data), .wd_rst(wd_rst), .wd_nmi(wd_nmi),
    .cfg_rd(cfg_rd), .cfg_locked(cfg_locked));

  always #4 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference
  int m_cfg, m_cnt, m_pre, m_hold;
  bit m_stage, m_locked, m_nmi;

  task automatic m_init();
    m_cfg = DEF_CFG; m_cnt = 255; m_pre = 0; m_stage = 0; m_locked = 0; m_nmi = 0;
  endtask

  // monitors
  int rst_len = 0, rst_pulses = 0, rst_rise = -1, nmi_cnt = 0, last_nmi = -1, exp_int = 0;
  bit prev_rst = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin m_init(); m_hold = 0; end
    else if (m_hold > 0) begin m_init(); m_hold--; end
    else begin
      bit en, tk, fire, take, ok;
      int per;
      en   = m_cfg[0];
      tk   = !m_cfg[2] || (m_pre == (1 << PRE_LOG) - 1);
      fire = en && tk && (m_cnt <= 1);
      if (fire && !m_cfg[1]) begin m_init(); m_hold = HOLD; end
      else begin
        take = cfg_we && !m_locked;
        ok   = svc_we && m_stage && (svc_data == KB);
        per  = take ? int'(cfg_wdata) >> 3 : m_cfg >> 3;
        m_nmi = fire;
        if (svc_we) m_stage = (svc_data == KA);
        if (take) begin m_cfg = int'(cfg_wdata); m_locked = 1; end
        if (fire || take || ok || !en) begin m_cnt = per; m_pre = 0; end
        else begin
          if (tk) m_cnt--;
          m_pre = (m_pre + 1) % (1 << PRE_LOG);
        end
      end
    end
    #2;
    if (!done) begin
      chk(wd_nmi == m_nmi, "R7 wd_nmi vs model", wd_nmi, m_nmi);
      chk(wd_rst == (m_hold > 0), "R8 wd_rst vs model", wd_rst, m_hold > 0);
      chk(cfg_locked == m_locked, "R3 cfg_locked vs model", cfg_locked, m_locked);
      chk(int'(cfg_rd) == m_cfg, "R4 cfg_rd vs model", cfg_rd, m_cfg);
      if (wd_rst) begin
        if (!prev_rst) rst_rise = cyc;
        rst_len++;
      end else if (prev_rst) begin
        chk(rst_len == HOLD, "R8 reset hold length", rst_len, HOLD);
        rst_pulses++; rst_len = 0;
      end
      prev_rst = wd_rst;
      if (wd_nmi) begin
        nmi_cnt++;
        if (last_nmi >= 0 && exp_int > 0)
          chk(cyc - last_nmi == exp_int, "R10 NMI spacing", cyc - last_nmi, exp_int);
        last_nmi = cyc;
      end
    end
  end

  task automatic wait_n(input int n); repeat (n) @(negedge clk); endtask
  task automatic cfg_write(input int v);
    @(negedge clk); cfg_we = 1; cfg_wdata = CFG_W'(v); @(negedge clk); cfg_we = 0;
  endtask
  task automatic svc(input logic [15:0] v);
    @(negedge clk); svc_we = 1; svc_data = v; @(negedge clk); svc_we = 0;
  endtask
  task automatic sys_reset();
    @(negedge clk); rst_n = 0; wait_n(3); rst_n = 1;
  endtask

  initial begin
    int rel, w;
    wait_n(3); rst_n = 1; rel = cyc;
    @(negedge clk);
    chk(int'(cfg_rd) == DEF_CFG, "R1 reset protection word", cfg_rd, DEF_CFG);
    chk(!cfg_locked && !wd_rst && !wd_nmi, "R1 reset outputs", {cfg_locked, wd_rst, wd_nmi}, 0);

    wait_n(4200);
    chk(rst_pulses == 1, "R2 default timeout gives reset", rst_pulses, 1);
    chk(rst_rise - rel == 255 * 16, "R2 default timeout length", rst_rise - rel, 255 * 16);
    chk(!cfg_locked && int'(cfg_rd) == DEF_CFG, "R8 post-reset state", cfg_rd, DEF_CFG);

    for (int i = 0; i < 4; i++) begin
      wait_n(3000); svc(KA); svc(KB);
    end
    chk(rst_pulses == 1 && !wd_rst, "R5 serviced, no timeout", rst_pulses, 1);

    svc(KB); svc(KA); svc(16'h1234); svc(KB);
    wait_n(3000);
    chk(rst_pulses == 1 && !wd_rst, "R6 before stale deadline", rst_pulses, 1);
    wait_n(1200);
    chk(rst_pulses == 2, "R6 stray keys did not reload", rst_pulses, 2);

    w = (20 << 3) | 3;
    cfg_write(w);
    chk(cfg_locked == 1 && int'(cfg_rd) == w, "R3 first write taken", cfg_rd, w);
    cfg_write(200 << 3);
    chk(int'(cfg_rd) == w, "R4 second write ignored", cfg_rd, w);
    nmi_cnt = 0; last_nmi = -1; exp_int = 20;
    wait_n(205);
    chk(nmi_cnt == 10, "R7 NMI pulses repeat, period 20", nmi_cnt, 10);
    chk(rst_pulses == 2, "R7 NMI mode gives no reset", rst_pulses, 2);

    sys_reset();
    exp_int = 0; last_nmi = -1; nmi_cnt = 0;
    cfg_write((5 << 3) | 7);
    exp_int = 80;
    wait_n(500);
    chk(nmi_cnt == 6, "R10 prescaled NMI count", nmi_cnt, 6);

    sys_reset();
    exp_int = 0; nmi_cnt = 0;
    cfg_write(3 << 3);
    wait_n(5000);
    chk(nmi_cnt == 0 && rst_pulses == 2, "R9 disabled stays silent", nmi_cnt + rst_pulses, 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    done = 1;
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule